// File: doc/BRIEF.md
# Programmable Interrupt Priority Controller

This block collects interrupt requests from a set of active-low external lines, a set of on-chip peripheral sources and four non-maskable sources. It picks the request with the highest priority, compares that priority with the processor's current mask and presents a registered request with a vector number and a level. Software gives each maskable source a 2-bit field. The field either switches the source off or places it on one of the three maskable levels. Each external line can be set to level-sensitive or falling-edge operation, and it reports whether a request is waiting.

The non-maskable tier sits at level 3 and is never held back by the mask. It covers a reset request, a sticky stack-error flag that only a stack-pointer write clears, an illegal-opcode event and a conditional-trap event. The surrounding core fetches the vector and runs the handler. When it takes a request it pulses `ack` together with the vector it serviced, and the block clears the latched request of that source.

Top module: `irqc_top`

## Requirements
- R1: Each maskable source has a 2-bit field in `cfg_level`. Field k sits at bits [2k+1:2k]. Fields 0, 1 and 2 belong to external lines A, B and C, and fields 3 and 4 belong to peripherals 0 and 1. The value 00 switches the source off, 01 gives level 0, 10 gives level 1 and 11 gives level 2.
- R2: With its `cfg_edge` bit at 0, an external line requests while it is low and stops as soon as it returns high, with nothing latched. Its `ext_pending` bit shows the sampled request.
- R3: With its `cfg_edge` bit at 1, a falling edge on an external line is latched. The request stays pending after the line returns high, and `ext_pending` reads 1 until the request is serviced.
- R4: A cycle with `ack`=1 clears the latched request of the source whose vector equals `ack_vector`. The sources this applies to are an edge-mode external line, the illegal-opcode source and the trap source. An acknowledge carrying any other vector leaves that request pending.
- R5: A winner at level 0 to 2 raises `irq_valid` only when its level is greater than or equal to `cpu_mask`. A request at exactly the mask level is not blocked.
- R6: The reset, stack-error, illegal and trap sources sit at level 3. They raise `irq_valid` with `irq_level`=3 whatever the value of `cpu_mask`.
- R7: The highest pending level wins. Ties between sources on that level go to the lowest vector number. The vectors are: reset 0, stack error 1, illegal 2, trap 3, line A 4, line B 5, line C 6, peripheral 0 7, peripheral 1 8.
- R8: A pulse on `stack_err_set` sets a sticky flag, and only a pulse on `sp_write` clears it. An acknowledge has no effect on the flag. When both pulses arrive in the same cycle, the flag ends up set.
- R9: A one-cycle pulse on `illegal_req` or `trap_req` is latched and keeps requesting until it is acknowledged.
- R10: All outputs are registered and read 0 after reset. `irq_vector` and `irq_level` read 0 whenever `irq_valid` is 0. External lines pass through one sampling register, and edge detection compares two successive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 10 | 2-bit enable/level field per maskable source |
| cfg_edge | input | 3 | Trigger mode per external line, 1 = falling edge |
| ext_req_n | input | 3 | Active-low external request lines |
| periph_req | input | 2 | Active-high peripheral requests |
| reset_req | input | 1 | Level-3 reset request, level-sensitive |
| illegal_req | input | 1 | Illegal-opcode event pulse |
| trap_req | input | 1 | Conditional-trap event pulse |
| stack_err_set | input | 1 | Sets the sticky stack-error flag |
| sp_write | input | 1 | Stack-pointer write, clears the stack-error flag |
| cpu_mask | input | 2 | Current processor priority level |
| ack | input | 1 | One-cycle service acknowledge |
| ack_vector | input | 4 | Vector being acknowledged |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_vector | output | 4 | Winning vector number |
| irq_level | output | 2 | Level of the winning request |
| ext_pending | output | 3 | Pending status per external line |
| stack_err_flag | output | 1 | Sticky stack-error flag |

## Verification
The bench builds the block with its default parameters: three external lines and two peripherals, which gives nine vectors. With these values every vector fits in four bits, and every tie between sources on one level can be produced. That includes two external lines against a peripheral, and all four non-maskable sources against each other. Random traffic flips the trigger modes, the fields and the mask while edges and acknowledges are in flight. This drives the set-wins-over-clear cases on the edge latches and on the stack-error flag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned FLD_W    = 2;
  localparam int unsigned NMI_CNT  = 4;
  localparam logic [LVL_W-1:0] LVL_NMI = 2'd3;

  localparam int unsigned SRC_RESET   = 0;
  localparam int unsigned SRC_STACK   = 1;
  localparam int unsigned SRC_ILLEGAL = 2;
  localparam int unsigned SRC_TRAP    = 3;

  typedef enum logic [FLD_W-1:0] {
    FLD_OFF = 2'b00,
    FLD_L0  = 2'b01,
    FLD_L1  = 2'b10,
    FLD_L2  = 2'b11
  } prio_fld_e;
endpackage

// File: rtl/irqc_fld_decode.sv
module irqc_fld_decode
  import irqc_pkg::*;
(
  input  logic [FLD_W-1:0] fld,
  output logic             en,
  output logic [LVL_W-1:0] lvl
);
  always_comb begin
    en  = 1'b1;
    lvl = '0;
    unique case (prio_fld_e'(fld))
      FLD_OFF: begin en = 1'b0; lvl = '0;    end
      FLD_L0:  lvl = 2'd0;
      FLD_L1:  lvl = 2'd1;
      FLD_L2:  lvl = 2'd2;
      default: begin en = 1'b0; lvl = '0;    end
    endcase
  end
endmodule

// File: rtl/irqc_ext_line.sv
module irqc_ext_line (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic edge_mode,
  input  logic ack_hit,
  output logic req,
  output logic pending
);
  logic samp_q, prev_q, pend_q;
  logic pend_d, fall;

  assign fall = prev_q & ~samp_q;

  always_comb begin
    if (edge_mode) pend_d = fall | (pend_q & ~ack_hit);
    else           pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      samp_q <= line_n;
      prev_q <= samp_q;
      pend_q <= pend_d;
    end
  end

  assign req     = edge_mode ? pend_q : ~samp_q;
  assign pending = req;

  // R3: a sampled falling edge in edge mode is latched
  p_edge_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && prev_q && !samp_q) |=> pend_q);
  // R2: level mode keeps nothing latched
  p_level_nolatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !pend_q);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC  = 9,
  parameter int unsigned VEC_W = 4
) (
  input  logic [NSRC-1:0]       act,
  input  logic [NSRC*LVL_W-1:0] lvl_flat,
  input  logic [LVL_W-1:0]      mask,
  output logic                  grant,
  output logic [VEC_W-1:0]      win_idx,
  output logic [LVL_W-1:0]      win_lvl
);
  logic [LVL_W-1:0] lvl_arr [NSRC];
  logic             found;

  for (genvar g = 0; g < NSRC; g++) begin : g_slice
    assign lvl_arr[g] = lvl_flat[g*LVL_W +: LVL_W];
  end

  always_comb begin
    found   = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i] && (!found || lvl_arr[i] >= win_lvl)) begin
        found   = 1'b1;
        win_lvl = lvl_arr[i];
        win_idx = VEC_W'(i);
      end
    end
  end

  assign grant = found && (win_lvl >= mask);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_EXT = 3,
  parameter int unsigned N_PER = 2,
  localparam int unsigned N_MSK   = N_EXT + N_PER,
  localparam int unsigned NSRC    = NMI_CNT + N_MSK,
  localparam int unsigned VEC_W   = $clog2(NSRC),
  localparam int unsigned EXT_BASE = NMI_CNT,
  localparam int unsigned PER_BASE = NMI_CNT + N_EXT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MSK*FLD_W-1:0] cfg_level,
  input  logic [N_EXT-1:0]       cfg_edge,
  input  logic [N_EXT-1:0]       ext_req_n,
  input  logic [N_PER-1:0]       periph_req,
  input  logic                   reset_req,
  input  logic                   illegal_req,
  input  logic                   trap_req,
  input  logic                   stack_err_set,
  input  logic                   sp_write,
  input  logic [LVL_W-1:0]       cpu_mask,
  input  logic                   ack,
  input  logic [VEC_W-1:0]       ack_vector,
  output logic                   irq_valid,
  output logic [VEC_W-1:0]       irq_vector,
  output logic [LVL_W-1:0]       irq_level,
  output logic [N_EXT-1:0]       ext_pending,
  output logic                   stack_err_flag
);
  logic [NSRC-1:0]       src_act;
  logic [NSRC*LVL_W-1:0] src_lvl;
  logic [N_MSK-1:0]      fld_en;
  logic [LVL_W-1:0]      fld_lvl [N_MSK];
  logic [N_EXT-1:0]      ext_req;

  logic stk_q, stk_d, ill_q, ill_d, trap_q, trap_d;
  logic grant;
  logic [VEC_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             valid_d;
  logic [VEC_W-1:0] vec_d;
  logic [LVL_W-1:0] lvl_d;

  // field decoders for every maskable source
  for (genvar k = 0; k < N_MSK; k++) begin : g_fld
    irqc_fld_decode i_dec (
      .fld (cfg_level[k*FLD_W +: FLD_W]),
      .en  (fld_en[k]),
      .lvl (fld_lvl[k])
    );
  end

  // external lines
  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    logic ack_hit;
    assign ack_hit = ack && (ack_vector == VEC_W'(EXT_BASE + e));
    irqc_ext_line i_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_n    (ext_req_n[e]),
      .edge_mode (cfg_edge[e]),
      .ack_hit   (ack_hit),
      .req       (ext_req[e]),
      .pending   (ext_pending[e])
    );
    assign src_act[EXT_BASE+e] = fld_en[e] & ext_req[e];
    assign src_lvl[(EXT_BASE+e)*LVL_W +: LVL_W] = fld_lvl[e];
  end

  // peripheral sources, level-sensitive
  for (genvar p = 0; p < N_PER; p++) begin : g_per
    assign src_act[PER_BASE+p] = fld_en[N_EXT+p] & periph_req[p];
    assign src_lvl[(PER_BASE+p)*LVL_W +: LVL_W] = fld_lvl[N_EXT+p];
  end

  // non-maskable tier
  always_comb begin
    stk_d  = stack_err_set | (stk_q & ~sp_write);
    ill_d  = illegal_req | (ill_q  & ~(ack && ack_vector == VEC_W'(SRC_ILLEGAL)));
    trap_d = trap_req    | (trap_q & ~(ack && ack_vector == VEC_W'(SRC_TRAP)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q  <= 1'b0;
      ill_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      stk_q  <= stk_d;
      ill_q  <= ill_d;
      trap_q <= trap_d;
    end
  end

  assign src_act[SRC_RESET]   = reset_req;
  assign src_act[SRC_STACK]   = stk_q;
  assign src_act[SRC_ILLEGAL] = ill_q;
  assign src_act[SRC_TRAP]    = trap_q;
  for (genvar n = 0; n < NMI_CNT; n++) begin : g_nmi
    assign src_lvl[n*LVL_W +: LVL_W] = LVL_NMI;
  end

  irqc_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) i_arb (
    .act      (src_act),
    .lvl_flat (src_lvl),
    .mask     (cpu_mask),
    .grant    (grant),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  always_comb begin
    valid_d = grant;
    vec_d   = grant ? win_idx : '0;
    lvl_d   = grant ? win_lvl : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_level  <= '0;
    end else begin
      irq_valid  <= valid_d;
      irq_vector <= vec_d;
      irq_level  <= lvl_d;
    end
  end

  assign stack_err_flag = stk_q;

  // R8: flag survives every cycle without a stack-pointer write
  p_stack_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_err_flag && !sp_write) |=> stack_err_flag);
  // R6: reset request is granted at level 3 regardless of mask
  p_nmi_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (irq_valid && irq_level == LVL_NMI));
  // R5: a granted request is never below the mask it was judged against
  p_mask_geq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level >= $past(cpu_mask)));
  // R10: idle outputs read zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_vector == '0 && irq_level == '0));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] cfg_level;
  logic [2:0] cfg_edge, ext_req_n;
  logic [1:0] periph_req, cpu_mask;
  logic       reset_req, illegal_req, trap_req, stack_err_set, sp_write, ack;
  logic [3:0] ack_vector;
  logic       irq_valid, stack_err_flag;
  logic [3:0] irq_vector;
  logic [1:0] irq_level;
  logic [2:0] ext_pending;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [2:0] m_s1, m_s2, m_pend;
  logic m_ill, m_trap, m_stk, m_valid;
  logic [3:0] m_vec;
  logic [1:0] m_lvl;

  always #10 clk = ~clk;

  irqc_top i_irqc_top (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_edge(cfg_edge),
    .ext_req_n(ext_req_n), .periph_req(periph_req), .reset_req(reset_req),
    .illegal_req(illegal_req), .trap_req(trap_req), .stack_err_set(stack_err_set),
    .sp_write(sp_write), .cpu_mask(cpu_mask), .ack(ack), .ack_vector(ack_vector),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
    .ext_pending(ext_pending), .stack_err_flag(stack_err_flag)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_status();
    logic [2:0] s;
    for (int e = 0; e < 3; e++) s[e] = cfg_edge[e] ? m_pend[e] : ~m_s1[e];
    return s;
  endfunction

  // one clock: compute the reference from requirements, advance, compare
  task automatic tick();
    int act_l [9];
    bit act_a [9];
    int best, w;
    logic [2:0] n_s1, n_s2, n_pend;
    logic n_ill, n_trap, n_stk;
    act_a[0] = reset_req; act_l[0] = 3;
    act_a[1] = m_stk;     act_l[1] = 3;
    act_a[2] = m_ill;     act_l[2] = 3;
    act_a[3] = m_trap;    act_l[3] = 3;
    for (int e = 0; e < 3; e++) begin
      act_a[4+e] = (cfg_level[2*e +: 2] != 0) && (cfg_edge[e] ? m_pend[e] : !m_s1[e]);
      act_l[4+e] = int'(cfg_level[2*e +: 2]) - 1;
    end
    for (int p = 0; p < 2; p++) begin
      act_a[7+p] = (cfg_level[2*(3+p) +: 2] != 0) && periph_req[p];
      act_l[7+p] = int'(cfg_level[2*(3+p) +: 2]) - 1;
    end
    best = -1; w = 0;
    for (int i = 0; i < 9; i++)
      if (act_a[i] && act_l[i] > best) begin best = act_l[i]; w = i; end
    for (int e = 0; e < 3; e++) begin
      n_s1[e] = ext_req_n[e];
      n_s2[e] = m_s1[e];
      n_pend[e] = cfg_edge[e] &&
                  ((m_s2[e] && !m_s1[e]) || (m_pend[e] && !(ack && ack_vector == 4'(4+e))));
    end
    n_ill  = illegal_req || (m_ill  && !(ack && ack_vector == 4'd2));
    n_trap = trap_req    || (m_trap && !(ack && ack_vector == 4'd3));
    n_stk  = stack_err_set || (m_stk && !sp_write);
    @(posedge clk);
    m_s1 = n_s1; m_s2 = n_s2; m_pend = n_pend;
    m_ill = n_ill; m_trap = n_trap; m_stk = n_stk;
    m_valid = (best >= 0) && (best >= int'(cpu_mask));
    m_vec = m_valid ? 4'(w) : 4'd0;
    m_lvl = m_valid ? 2'(best) : 2'd0;
    @(negedge clk);
    chk("R7 R10 valid", irq_valid, m_valid);
    chk("R7 vector", irq_vector, m_vec);
    chk("R5 level", irq_level, m_lvl);
    chk("R3 status", ext_pending, exp_status());
    chk("R8 flag", stack_err_flag, m_stk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulses_off();
    illegal_req = 0; trap_req = 0; stack_err_set = 0; sp_write = 0; ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; cfg_level = 0; cfg_edge = 0; ext_req_n = 3'b111; periph_req = 0;
    reset_req = 0; cpu_mask = 0; ack_vector = 0; pulses_off();
    m_s1 = 3'b111; m_s2 = 3'b111; m_pend = 0; m_ill = 0; m_trap = 0; m_stk = 0;
    m_valid = 0; m_vec = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 reset valid", irq_valid, 0);
    chk("R10 reset vector", irq_vector, 0);
    chk("R10 reset level", irq_level, 0);
    chk("R10 reset status", ext_pending, 0);
    chk("R10 reset flag", stack_err_flag, 0);

    // R1: disabled field blocks a request
    ext_req_n = 3'b110; ticks(4);
    chk("R1 field 00 off", irq_valid, 0);
    cfg_level[1:0] = 2'b11; ticks(2);
    chk("R1 field 11 valid", irq_valid, 1);
    chk("R1 field 11 level", irq_level, 2);
    chk("R1 field 11 vector", irq_vector, 4);
    // R5: equal level passes, lower blocked
    cpu_mask = 2; ticks(2);
    chk("R5 equal level passes", irq_valid, 1);
    cpu_mask = 3; ticks(2);
    chk("R5 mask 3 blocks", irq_valid, 0);
    cpu_mask = 1; cfg_level[1:0] = 2'b10; ticks(2);
    chk("R1 field 10 level", irq_level, 1);
    cpu_mask = 2; ticks(2);
    chk("R5 below mask blocked", irq_valid, 0);
    // R2: level mode follows the line
    chk("R2 status while low", ext_pending[0], 1);
    ext_req_n = 3'b111; cpu_mask = 0; ticks(3);
    chk("R2 status after release", ext_pending[0], 0);
    chk("R2 no request after release", irq_valid, 0);

    // R3: edge mode latches a short low pulse
    cfg_level[1:0] = 2'b11; cfg_edge = 3'b001; ticks(3);
    ext_req_n = 3'b110; tick(); ext_req_n = 3'b111; ticks(4);
    chk("R3 edge pending", ext_pending[0], 1);
    chk("R3 edge request vector", irq_vector, 4);
    // R4: acknowledge of another vector has no effect
    ack = 1; ack_vector = 5; tick(); ack = 0; ticks(2);
    chk("R4 other ack keeps pending", ext_pending[0], 1);
    ack = 1; ack_vector = 4; tick(); ack = 0; ticks(2);
    chk("R4 matching ack clears", ext_pending[0], 0);
    chk("R4 request gone", irq_valid, 0);
    cfg_edge = 0;

    // R7: tie on level 1 between line B and peripheral 0
    cfg_level = 10'b00_10_11_10_00; ext_req_n = 3'b101; periph_req = 2'b01; ticks(3);
    chk("R7 tie goes to line B", irq_vector, 5);
    ext_req_n = 3'b111; ticks(3);
    chk("R7 peripheral 0 alone", irq_vector, 7);
    ext_req_n = 3'b011; ticks(3);
    chk("R7 higher level wins", irq_vector, 6);
    ext_req_n = 3'b111; periph_req = 0; ticks(3);

    // R6 / R9: trap pulse bypasses mask 3 and stays latched
    cpu_mask = 3; trap_req = 1; tick(); trap_req = 0; ticks(2);
    chk("R6 trap level", irq_level, 3);
    chk("R6 trap vector", irq_vector, 3);
    ticks(5);
    chk("R9 trap still latched", irq_valid, 1);
    ack = 1; ack_vector = 3; tick(); ack = 0; ticks(2);
    chk("R9 trap acked", irq_valid, 0);
    illegal_req = 1; tick(); illegal_req = 0; ticks(4);
    chk("R9 illegal latched", irq_vector, 2);
    ack = 1; ack_vector = 2; tick(); ack = 0; ticks(2);
    chk("R4 illegal acked", irq_valid, 0);

    // R8: sticky stack error
    stack_err_set = 1; tick(); stack_err_set = 0; ticks(2);
    chk("R8 flag set", stack_err_flag, 1);
    chk("R8 stack vector", irq_vector, 1);
    ack = 1; ack_vector = 1; tick(); ack = 0; ticks(2);
    chk("R8 ack ignored", stack_err_flag, 1);
    // R6: reset request beats stack error
    reset_req = 1; ticks(2);
    chk("R6 reset vector", irq_vector, 0);
    reset_req = 0; sp_write = 1; tick(); sp_write = 0; ticks(2);
    chk("R8 sp write clears", stack_err_flag, 0);
    stack_err_set = 1; sp_write = 1; tick(); pulses_off(); ticks(1);
    chk("R8 set wins", stack_err_flag, 1);
    sp_write = 1; tick(); sp_write = 0; ticks(2);
    cpu_mask = 0;

    // random phase, checked against the reference each clock
    for (int c = 0; c < 4000; c++) begin
      if (c % 64 == 0) begin
        cfg_level = 10'($urandom);
        cfg_edge  = 3'($urandom);
      end
      if ($urandom_range(7) == 0) cpu_mask = 2'($urandom);
      for (int e = 0; e < 3; e++)
        if ($urandom_range(5) == 0) ext_req_n[e] = ~ext_req_n[e];
      if ($urandom_range(7) == 0) periph_req = 2'($urandom);
      reset_req     = ($urandom_range(31) == 0);
      illegal_req   = ($urandom_range(23) == 0);
      trap_req      = ($urandom_range(23) == 0);
      stack_err_set = ($urandom_range(47) == 0);
      sp_write      = ($urandom_range(11) == 0);
      ack           = ($urandom_range(3) == 0);
      ack_vector    = ($urandom_range(1) == 0) ? irq_vector : 4'($urandom_range(8));
      tick();
    end
    pulses_off(); reset_req = 0;
    ticks(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule